// File: doc/BRIEF.md
# Health Alert Warning Threshold Register

This block keeps the programmable warning thresholds that a memory device uses to raise health alerts: a life-used warning, an over-temperature warning, an under-temperature warning and two corrected-error-count warnings. A command port delivers either a "set" request carrying a 12-byte payload or a "get" request with no payload. For a set, every field whose selection bit is high is judged against a fixed critical limit. Fields that pass are written, and each one sets its enabled-alert bit. The result is reported one cycle later as a single-cycle done pulse with a status code.

The critical limits are fixed by parameters when the block is built, and software cannot change them. The stored configuration, including the critical limits and the enabled-alert bits, is always visible on the read-port outputs. A get request returns status 0 and leaves everything unchanged, so the host reads the configuration from those outputs. Temperature sensing, wear counting, alert generation and the mailbox transport live outside the block.

Top module: `alert_threshold_regs`

## Requirements
- R1: When reset is released, the enabled-alert bits, every warning register, the done output and the status output all read zero.
- R2: Every cycle in which `cmd_valid` is high produces `rsp_done` high in the next cycle and only then. The status that goes with it is 0 for success, 1 for invalid input and 2 for a bad length.
- R3: A set whose `cmd_len` is not 12, or a get whose `cmd_len` is not 0, returns status 2 and changes no register.
- R4: The life-used value is payload byte 2 and is selected by mask bit 0 (payload byte 0). It is accepted only when it is below the life-used critical limit as an unsigned number. Otherwise the status is 1.
- R5: The over-temperature value is bytes 4–5, little-endian, selected by mask bit 1. It is accepted only when it is strictly below the over-temperature critical limit, comparing both as signed 16-bit numbers.
- R6: The under-temperature value is bytes 6–7, selected by mask bit 2. It is accepted only when it is strictly above the under-temperature critical limit, comparing both as signed 16-bit numbers.
- R7: The corrected volatile-error value (bytes 8–9, mask bit 3) and the corrected persistent-error value (bytes 10–11, mask bit 4) are accepted with any value.
- R8: An accepted field is written to its warning register and sets enabled-alert bit n, where n is its mask bit. Fields whose mask bit is clear keep their value, and enabled-alert bits are never cleared.
- R9: Fields are judged in mask-bit order from 0 to 4. The first rejected field ends processing with status 1. Fields before it stay written, and the rejected field and all later fields are not written.
- R10: Payload byte 1, payload byte 3 and mask bits 5 to 7 have no effect on any register or on the status.
- R11: A get with length 0 returns status 0 and changes nothing. The critical-limit outputs always show the build-time parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_set | input | 1 | 1 = set request, 0 = get request |
| cmd_len | input | 8 | Payload byte count of the request |
| cmd_payload | input | 96 | Request bytes; byte k in bits 8k+7:8k |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid input, 2 bad length |
| cfg_enables | output | 5 | Enabled-alert bits, indexed by mask bit |
| cfg_life_warn | output | 8 | Life-used warning |
| cfg_over_warn | output | 16 | Over-temperature warning |
| cfg_under_warn | output | 16 | Under-temperature warning |
| cfg_vol_warn | output | 16 | Corrected volatile-error warning |
| cfg_per_warn | output | 16 | Corrected persistent-error warning |
| cfg_life_crit | output | 8 | Life-used critical limit |
| cfg_over_crit | output | 16 | Over-temperature critical limit |
| cfg_under_crit | output | 16 | Under-temperature critical limit |

## Verification
Within one cycle, a set can both commit some fields and reject another field. The earlier fields are written while the rejected field and the ones after it are not. Multi-field payloads are used to provoke this: the life-used and over-temperature values are valid and the under-temperature value is out of range. The bench checks that the invalid-input status appears in the same response as the partial register update and enable bits, and that the rejected field and every later field keep their old values. A cycle-by-cycle model compares every output at each clock, and back-to-back commands test whether a second request can overlap the response of the first.

// File: rtl/alert_cfg_pkg.sv
// Shared definitions for the alert threshold register.
// Holds the status codes, the comparison modes and the field-to-mode map.
// Assumes five fields, indexed by their bit position in the selection mask.
package alert_cfg_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int FIELD_W    = 16;
    localparam int SET_LEN    = 12;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_BAD_INPUT = 2'd1,
        ST_BAD_LEN   = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        CMP_BELOW = 2'd0,
        CMP_ABOVE = 2'd1,
        CMP_ANY   = 2'd2
    } cmp_mode_e;

    // Direction of the limit check for each field.
    function automatic cmp_mode_e field_mode(input int idx);
        if (idx == 0 || idx == 1) return CMP_BELOW;
        if (idx == 2)             return CMP_ABOVE;
        return CMP_ANY;
    endfunction

    // Temperature fields are two's complement.
    function automatic bit field_signed(input int idx);
        return (idx == 1 || idx == 2);
    endfunction

endpackage

// File: rtl/alert_field_judge.sv
// Judges one requested warning value against its critical limit.
// Assumes the value and the limit arrive zero-extended (unsigned fields) or
// at full width (signed fields). MODE picks the direction of the check.
module alert_field_judge
    import alert_cfg_pkg::*;
#(
    parameter int        W         = 16,
    parameter cmp_mode_e MODE      = CMP_ANY,
    parameter bit        IS_SIGNED = 1'b0
) (
    input  logic [W-1:0] req_val,
    input  logic [W-1:0] crit_val,
    output logic         pass
);

    logic signed [W:0] req_x;
    logic signed [W:0] crit_x;

    // Widen both operands by one bit so that one signed compare covers both number kinds.
    always_comb begin
        req_x  = IS_SIGNED ? {req_val[W-1],  req_val}  : {1'b0, req_val};
        crit_x = IS_SIGNED ? {crit_val[W-1], crit_val} : {1'b0, crit_val};
    end

    // Apply the direction rule of this field.
    always_comb begin
        case (MODE)
            CMP_BELOW: pass = (req_x < crit_x);
            CMP_ABOVE: pass = (req_x > crit_x);
            default:   pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/alert_commit_order.sv
// Turns the selection mask and the per-field judgements into write enables.
// Fields are walked from index 0 upward. The first selected field that fails
// blocks itself and every higher field; fields below it are still written.
module alert_commit_order #(
    parameter int N = 5
) (
    input  logic [N-1:0] sel,
    input  logic [N-1:0] pass,
    output logic [N-1:0] commit,
    output logic         reject
);

    // Ordered scan that stops at the first failure.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        commit  = '0;
        reject  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel[i] && !blocked) begin
                if (pass[i]) begin
                    commit[i] = 1'b1;
                end else begin
                    reject  = 1'b1;
                    blocked = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/alert_warn_store.sv
// Warning registers and enabled-alert bits, one set per field.
// Assumes commit is already masked by the command and length checks.
// Enable bits are only ever set, never cleared, while reset is high.
module alert_warn_store #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] commit,
    input  logic [W-1:0] req_v  [N],
    output logic [W-1:0] warn_q [N],
    output logic [N-1:0] en_q
);

    for (genvar g = 0; g < N; g++) begin : g_field
        // Load one warning register and set its enable bit when the field is committed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                warn_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (commit[g]) begin
                warn_q[g] <= req_v[g];
                en_q[g]   <= 1'b1;
            end
        end
    end

    p_enable_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

// File: rtl/alert_threshold_regs.sv
// Top of the alert threshold register block.
// Decodes the 12-byte little-endian set payload and checks the request length.
// Judges each selected field against its build-time critical limit, commits the
// fields in order, and reports done and status one cycle after each request.
module alert_threshold_regs
    import alert_cfg_pkg::*;
#(
    parameter logic [7:0]  CRIT_LIFE  = 8'd100,
    parameter logic [15:0] CRIT_OVER  = 16'h0064,
    parameter logic [15:0] CRIT_UNDER = 16'hFFF6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_set,
    input  logic [7:0]  cmd_len,
    input  logic [95:0] cmd_payload,
    output logic        rsp_done,
    output logic [1:0]  rsp_status,
    output logic [4:0]  cfg_enables,
    output logic [7:0]  cfg_life_warn,
    output logic [15:0] cfg_over_warn,
    output logic [15:0] cfg_under_warn,
    output logic [15:0] cfg_vol_warn,
    output logic [15:0] cfg_per_warn,
    output logic [7:0]  cfg_life_crit,
    output logic [15:0] cfg_over_crit,
    output logic [15:0] cfg_under_crit
);

    localparam int N = NUM_FIELDS;
    localparam int W = FIELD_W;

    logic [W-1:0] req_v  [N];
    logic [W-1:0] crit_v [N];
    logic [W-1:0] warn_q [N];
    logic [N-1:0] pass;
    logic [N-1:0] commit_raw;
    logic [N-1:0] commit;
    logic [N-1:0] sel;
    logic         reject;
    logic         len_ok;
    logic         apply;
    status_e      status_nxt;
    status_e      status_q;
    logic         done_q;

    // Extract the field values from the payload (little-endian byte order).
    always_comb begin
        sel      = cmd_payload[N-1:0];
        req_v[0] = {8'h00, cmd_payload[23:16]};
        req_v[1] = cmd_payload[47:32];
        req_v[2] = cmd_payload[63:48];
        req_v[3] = cmd_payload[79:64];
        req_v[4] = cmd_payload[95:80];
    end

    // Critical limits per field; the error-count fields have none.
    always_comb begin
        crit_v[0] = {8'h00, CRIT_LIFE};
        crit_v[1] = CRIT_OVER;
        crit_v[2] = CRIT_UNDER;
        crit_v[3] = '0;
        crit_v[4] = '0;
    end

    for (genvar g = 0; g < N; g++) begin : g_judge
        alert_field_judge #(
            .W         (W),
            .MODE      (field_mode(g)),
            .IS_SIGNED (field_signed(g))
        ) u_judge (
            .req_val  (req_v[g]),
            .crit_val (crit_v[g]),
            .pass     (pass[g])
        );
    end

    alert_commit_order #(.N(N)) u_order (
        .sel    (sel),
        .pass   (pass),
        .commit (commit_raw),
        .reject (reject)
    );

    // Gate the commits with the command type and the length check, and pick the status.
    always_comb begin
        len_ok = cmd_set ? (cmd_len == 8'(SET_LEN)) : (cmd_len == 8'd0);
        apply  = cmd_valid && cmd_set && len_ok;
        commit = apply ? commit_raw : '0;
        if (!len_ok)               status_nxt = ST_BAD_LEN;
        else if (cmd_set && reject) status_nxt = ST_BAD_INPUT;
        else                        status_nxt = ST_OK;
    end

    alert_warn_store #(.N(N), .W(W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .req_v  (req_v),
        .warn_q (warn_q),
        .en_q   (cfg_enables)
    );

    // Register the response pulse and its status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            status_q <= ST_OK;
        end else begin
            done_q <= cmd_valid;
            if (cmd_valid) status_q <= status_nxt;
        end
    end

    // Drive the read port.
    always_comb begin
        rsp_done       = done_q;
        rsp_status     = status_q;
        cfg_life_warn  = warn_q[0][7:0];
        cfg_over_warn  = warn_q[1];
        cfg_under_warn = warn_q[2];
        cfg_vol_warn   = warn_q[3];
        cfg_per_warn   = warn_q[4];
        cfg_life_crit  = CRIT_LIFE;
        cfg_over_crit  = CRIT_OVER;
        cfg_under_crit = CRIT_UNDER;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_done);

    p_len_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !len_ok) |=> (rsp_status == ST_BAD_LEN) && $stable(cfg_enables)
            && $stable(cfg_life_warn) && $stable(cfg_over_warn) && $stable(cfg_under_warn)
            && $stable(cfg_vol_warn) && $stable(cfg_per_warn));

    p_life_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enables[0] |-> (warn_q[0] < {8'h00, CRIT_LIFE}));

    p_over_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enables[1] |-> ($signed(cfg_over_warn) < $signed(CRIT_OVER)));

    p_under_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enables[2] |-> ($signed(cfg_under_warn) > $signed(CRIT_UNDER)));

    p_first_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && sel[0] && (cmd_payload[23:16] >= CRIT_LIFE)) |=>
            (rsp_status == ST_BAD_INPUT) && $stable(cfg_enables)
            && $stable(cfg_over_warn) && $stable(cfg_under_warn)
            && $stable(cfg_vol_warn) && $stable(cfg_per_warn));

    p_ignored_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && (sel == '0) && ((cmd_payload[15:8] != 8'h00) || (cmd_payload[31:24] != 8'h00)
            || (cmd_payload[7:N] != '0))) |=>
            (rsp_status == ST_OK) && $stable(cfg_enables) && $stable(cfg_life_warn));

    p_get_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_set && (cmd_len == 8'd0)) |=>
            (rsp_status == ST_OK) && $stable(cfg_enables));

endmodule

// File: tb/alert_threshold_regs_bench.sv
module alert_threshold_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_set = 1'b0;
    logic [7:0]  cmd_len = '0;
    logic [95:0] cmd_payload = '0;
    logic        rsp_done;
    logic [1:0]  rsp_status;
    logic [4:0]  cfg_enables;
    logic [7:0]  cfg_life_warn;
    logic [15:0] cfg_over_warn, cfg_under_warn, cfg_vol_warn, cfg_per_warn;
    logic [7:0]  cfg_life_crit;
    logic [15:0] cfg_over_crit, cfg_under_crit;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // reference model state
    int m_en, m_life, m_over, m_under, m_vol, m_per, m_status;
    bit m_done;

    always #10 clk = ~clk;

    alert_threshold_regs u_alert_threshold_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
        .cmd_len(cmd_len), .cmd_payload(cmd_payload), .rsp_done(rsp_done),
        .rsp_status(rsp_status), .cfg_enables(cfg_enables), .cfg_life_warn(cfg_life_warn),
        .cfg_over_warn(cfg_over_warn), .cfg_under_warn(cfg_under_warn),
        .cfg_vol_warn(cfg_vol_warn), .cfg_per_warn(cfg_per_warn),
        .cfg_life_crit(cfg_life_crit), .cfg_over_crit(cfg_over_crit),
        .cfg_under_crit(cfg_under_crit)
    );

    function automatic int s16(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic logic [95:0] pl(input logic [7:0] mask, input logic [7:0] act,
                                       input logic [7:0] life, input logic [7:0] rsv,
                                       input logic [15:0] ov, input logic [15:0] un,
                                       input logic [15:0] vo, input logic [15:0] pe);
        return {pe, vo, un, ov, rsv, life, act, mask};
    endfunction

    // behavioural reference model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_life = 0; m_over = 0; m_under = 0; m_vol = 0; m_per = 0;
            m_status = 0; m_done = 0;
        end else begin
            m_done = cmd_valid;
            if (cmd_valid) begin
                if (cmd_set && cmd_len != 12) m_status = 2;
                else if (!cmd_set && cmd_len != 0) m_status = 2;
                else if (!cmd_set) m_status = 0;
                else begin
                    int mask, lv, ov, un, vo, pe;
                    bit stop;
                    mask = cmd_payload[7:0];
                    lv = cmd_payload[23:16];
                    ov = cmd_payload[47:32];
                    un = cmd_payload[63:48];
                    vo = cmd_payload[79:64];
                    pe = cmd_payload[95:80];
                    stop = 0;
                    m_status = 0;
                    for (int i = 0; i < 5; i++) begin
                        if (!stop && mask[i]) begin
                            bit ok;
                            case (i)
                                0: ok = lv < 100;
                                1: ok = s16(ov) < 100;
                                2: ok = s16(un) > -10;
                                default: ok = 1;
                            endcase
                            if (!ok) begin
                                stop = 1;
                                m_status = 1;
                            end else begin
                                case (i)
                                    0: m_life = lv;
                                    1: m_over = ov;
                                    2: m_under = un;
                                    3: m_vol = vo;
                                    default: m_per = pe;
                                endcase
                                m_en = m_en | (1 << i);
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            chk({cur_req, " done"}, int'(rsp_done), int'(m_done));
            if (m_done) chk({cur_req, " status"}, int'(rsp_status), m_status);
            chk({cur_req, " enables"}, int'(cfg_enables), m_en);
            chk({cur_req, " life"}, int'(cfg_life_warn), m_life);
            chk({cur_req, " over"}, int'(cfg_over_warn), m_over);
            chk({cur_req, " under"}, int'(cfg_under_warn), m_under);
            chk({cur_req, " vol"}, int'(cfg_vol_warn), m_vol);
            chk({cur_req, " per"}, int'(cfg_per_warn), m_per);
        end
    end

    task automatic send(input bit is_set, input int len, input logic [95:0] p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_set = is_set; cmd_len = 8'(len); cmd_payload = p;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 enables", int'(cfg_enables), 0);
        chk("R1 life", int'(cfg_life_warn), 0);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 status", int'(rsp_status), 0);
        chk("R11 life crit", int'(cfg_life_crit), 100);
        chk("R11 over crit", int'(cfg_over_crit), 16'h0064);
        chk("R11 under crit", int'(cfg_under_crit), 16'hFFF6);
        cmp_on = 1;

        cur_req = "R4";
        send(1, 12, pl(8'h01, 0, 99, 0, 0, 0, 0, 0));
        chk("R4 accept 99", int'(rsp_status), 0);
        chk("R8 life written", int'(cfg_life_warn), 99);
        chk("R8 enable bit0", int'(cfg_enables), 5'h01);
        send(1, 12, pl(8'h01, 0, 100, 0, 0, 0, 0, 0));
        chk("R4 reject equal", int'(rsp_status), 1);
        chk("R4 life kept", int'(cfg_life_warn), 99);

        cur_req = "R5";
        send(1, 12, pl(8'h02, 0, 0, 0, 16'h0063, 0, 0, 0));
        chk("R5 accept 0x63", int'(rsp_status), 0);
        send(1, 12, pl(8'h02, 0, 0, 0, 16'h0064, 0, 0, 0));
        chk("R5 reject equal", int'(rsp_status), 1);
        chk("R5 over kept", int'(cfg_over_warn), 16'h0063);
        send(1, 12, pl(8'h02, 0, 0, 0, 16'hFF00, 0, 0, 0));
        chk("R5 negative accepted", int'(rsp_status), 0);
        chk("R5 over written", int'(cfg_over_warn), 16'hFF00);

        cur_req = "R6";
        send(1, 12, pl(8'h04, 0, 0, 0, 0, 16'hFFF6, 0, 0));
        chk("R6 reject equal", int'(rsp_status), 1);
        send(1, 12, pl(8'h04, 0, 0, 0, 0, 16'h8000, 0, 0));
        chk("R6 reject very negative", int'(rsp_status), 1);
        chk("R6 under kept", int'(cfg_under_warn), 0);
        send(1, 12, pl(8'h04, 0, 0, 0, 0, 16'hFFF7, 0, 0));
        chk("R6 accept -9", int'(rsp_status), 0);
        chk("R6 under written", int'(cfg_under_warn), 16'hFFF7);

        cur_req = "R7";
        send(1, 12, pl(8'h18, 0, 0, 0, 0, 0, 16'hFFFF, 16'h0000));
        chk("R7 status", int'(rsp_status), 0);
        chk("R7 vol", int'(cfg_vol_warn), 16'hFFFF);
        chk("R8 all enables", int'(cfg_enables), 5'h1F);

        cur_req = "R9";
        send(1, 12, pl(8'h07, 0, 50, 0, 16'h0010, 16'hFFF0, 0, 0));
        chk("R9 status", int'(rsp_status), 1);
        chk("R9 life committed", int'(cfg_life_warn), 50);
        chk("R9 over committed", int'(cfg_over_warn), 16'h0010);
        chk("R9 under untouched", int'(cfg_under_warn), 16'hFFF7);
        send(1, 12, pl(8'h1F, 0, 200, 0, 16'h0001, 16'h0000, 16'h1234, 16'h5678));
        chk("R9 first fails", int'(rsp_status), 1);
        chk("R9 vol untouched", int'(cfg_vol_warn), 16'hFFFF);
        chk("R9 per untouched", int'(cfg_per_warn), 0);

        cur_req = "R10";
        send(1, 12, pl(8'hE0, 8'hFF, 8'h11, 8'hAA, 16'h1111, 16'h2222, 16'h3333, 16'h4444));
        chk("R10 high mask ok", int'(rsp_status), 0);
        chk("R10 life unchanged", int'(cfg_life_warn), 50);
        chk("R10 vol unchanged", int'(cfg_vol_warn), 16'hFFFF);
        send(1, 12, pl(8'h08, 8'hFF, 8'h11, 8'hAA, 16'h1111, 16'h2222, 16'h0042, 16'h4444));
        chk("R10 vol only", int'(cfg_vol_warn), 16'h0042);
        chk("R10 per unchanged", int'(cfg_per_warn), 0);

        cur_req = "R3";
        send(1, 11, pl(8'h1F, 0, 10, 0, 0, 0, 1, 1));
        chk("R3 short set", int'(rsp_status), 2);
        chk("R3 life kept", int'(cfg_life_warn), 50);
        send(1, 13, pl(8'h01, 0, 10, 0, 0, 0, 0, 0));
        chk("R3 long set", int'(rsp_status), 2);
        send(0, 1, '0);
        chk("R3 get with data", int'(rsp_status), 2);

        cur_req = "R11";
        send(0, 0, pl(8'h1F, 0, 1, 0, 0, 0, 0, 0));
        chk("R11 get ok", int'(rsp_status), 0);
        chk("R11 life unchanged", int'(cfg_life_warn), 50);

        cur_req = "R2";
        @(negedge clk);
        cmd_valid = 1; cmd_set = 1; cmd_len = 12;
        cmd_payload = pl(8'h10, 0, 0, 0, 0, 0, 0, 16'h0007);
        @(negedge clk);
        chk("R2 first done", int'(rsp_done), 1);
        cmd_set = 0; cmd_len = 0;
        @(negedge clk);
        chk("R2 second done", int'(rsp_done), 1);
        chk("R2 second status", int'(rsp_status), 0);
        chk("R2 per written", int'(cfg_per_warn), 16'h0007);
        cmd_valid = 0;
        @(negedge clk);
        chk("R2 done falls", int'(rsp_done), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule